// File: doc/BRIEF.md
# Sub-Word Row Memory Lane Aligner

This block sits between a load/store pipe and a memory whose rows are several bytes wide. It takes a byte-addressed load or store of 1, 2, 4 or 8 bytes and turns it into row accesses. For a load it reads the row, picks out the addressed bytes and right-aligns them. For a store it reads the row, replaces only the addressed bytes, and writes the row back. Either kind of access can reverse its bytes over the access width, which converts between endiannesses.

Requests use a valid/ready handshake. The block takes one request at a time and answers each with a single response cycle. A misaligned request is not performed. The response raises an error flag instead. The number of bytes per row is a parameter: eight for a data memory, four for an instruction memory. The memory port has a read strobe, a write strobe, a row index, write data and read data. Read data is valid one clock after the read strobe.

The controller has four states. `IDLE` accepts a request. It moves to `FAULT` when the request is illegal and to `FETCH` otherwise. `FETCH` issues the row read and always moves to `APPLY`. `APPLY` returns the load result, or writes the merged row for a store, and then returns to `IDLE`. `FAULT` gives the error response and returns to `IDLE`.

Top module: `lane_aligner_top`

## Requirements
- R1: The row index placed on `mem_row` is the byte address shifted right by log2 of `ROW_BYTES`. The byte offset within the row is the address's low log2(`ROW_BYTES`) bits. Row byte k occupies row bits [8k+7:8k].
- R2: `req_size` encodes the access width as 1 << `req_size` bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8). A request is legal only when the width is at most `ROW_BYTES` and the byte offset is a multiple of the width. An illegal request produces `rsp_valid` and `rsp_err` together for exactly one cycle, in the cycle after acceptance. No memory read or write takes place for it.
- R3: A legal load raises `mem_re` in the cycle after acceptance and responds in the next cycle, with `rsp_err` low. Result byte k is row byte (offset + k) for k below the width. Bytes at or above the width read as zero.
- R4: A legal store raises `mem_re` in the cycle after acceptance. In the next cycle it raises `mem_we` with the same row index and gives its response (`rsp_err` low). The written row equals the old row with only the addressed bytes replaced. All other row bytes are preserved.
- R5: With `req_swap` high, the bytes are reversed over the access width. For a store this happens before merging: memory byte (offset + k) receives store byte (width - 1 - k). For a load it happens after extraction: result byte k is memory byte (offset + width - 1 - k).
- R6: `req_ready` is high only in `IDLE`. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low until the response cycle has passed.
- R7: After reset the block is in `IDLE`: `req_ready` is high, and `rsp_valid`, `rsp_err`, `mem_re` and `mem_we` are low.
- R8: Store data bytes at or above the access width have no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width as log2 of the byte count |
| req_swap | input | 1 | Reverse bytes over the access width |
| req_wdata | input | ROW_BYTES*8 | Store data, right-aligned |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Misaligned or oversize request, not performed |
| rsp_data | output | ROW_BYTES*8 | Load result, right-aligned; zero for stores and errors |
| mem_re | output | 1 | Row read strobe |
| mem_we | output | 1 | Row write strobe |
| mem_row | output | ADDR_W-log2(ROW_BYTES) | Row index |
| mem_wdata | output | ROW_BYTES*8 | Merged row for writing |
| mem_rdata | input | ROW_BYTES*8 | Row read data, valid one cycle after `mem_re` |

## Verification
The assertions take two things for granted. First, the memory returns `mem_rdata` exactly one cycle after `mem_re`. Second, request fields are examined only on the accepting edge, so they need to be meaningful only while `req_valid` is high. The bench drives a memory model with exactly that one-cycle read latency. It changes request fields only when raising `req_valid`, at the falling edge, and it drops `req_valid` just after the accepting edge. The sweep covers every width, offset and swap setting. Each store is read back with both swap settings and as a full row, and the results are compared against a byte-level model held in the bench.

// File: rtl/lane_aligner_pkg.sv
`timescale 1ns/1ps
package lane_aligner_pkg;

    localparam int SIZE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2,
        ST_FAULT = 2'd3
    } lane_state_e;

    function automatic int width_bytes(input logic [SIZE_W-1:0] sz);
        return 1 << sz;
    endfunction

endpackage

// File: rtl/lane_swap.sv
`timescale 1ns/1ps
// Reverses byte order over the access width when enabled; passes through otherwise.
module lane_swap
    import lane_aligner_pkg::*;
#(
    parameter int BYTES = 8
) (
    input  logic [BYTES*8-1:0] din,
    input  logic [SIZE_W-1:0]  size,
    input  logic               en,
    output logic [BYTES*8-1:0] dout
);
    always_comb begin
        int nb;
        nb   = width_bytes(size);
        dout = '0;
        if (!en) begin
            dout = din;
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                for (int j = 0; j < BYTES; j++) begin
                    if (i < nb && j == nb - 1 - i) begin
                        dout[i*8 +: 8] = din[j*8 +: 8];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lane_extract.sv
`timescale 1ns/1ps
// Load path: selects the addressed bytes of a row and right-aligns them.
module lane_extract
    import lane_aligner_pkg::*;
#(
    parameter int BYTES = 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [BYTES*8-1:0] row,
    input  logic [OFF_W-1:0]   off,
    input  logic [SIZE_W-1:0]  size,
    output logic [BYTES*8-1:0] dout
);
    always_comb begin
        int nb;
        nb   = width_bytes(size);
        dout = '0;
        for (int i = 0; i < BYTES; i++) begin
            for (int j = 0; j < BYTES; j++) begin
                if (i < nb && j == i + int'(off)) begin
                    dout[i*8 +: 8] = row[j*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/lane_merge.sv
`timescale 1ns/1ps
// Store path: replaces the addressed bytes of a row with right-aligned data.
module lane_merge
    import lane_aligner_pkg::*;
#(
    parameter int BYTES = 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [BYTES*8-1:0] row,
    input  logic [BYTES*8-1:0] wdata,
    input  logic [OFF_W-1:0]   off,
    input  logic [SIZE_W-1:0]  size,
    output logic [BYTES*8-1:0] merged
);
    always_comb begin
        int nb;
        nb     = width_bytes(size);
        merged = row;
        for (int j = 0; j < BYTES; j++) begin
            for (int i = 0; i < BYTES; i++) begin
                if (i < nb && j == i + int'(off)) begin
                    merged[j*8 +: 8] = wdata[i*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/lane_aligner_top.sv
`timescale 1ns/1ps
module lane_aligner_top
    import lane_aligner_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    parameter int ADDR_W    = 10,
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = ADDR_W - OFF_W,
    localparam int DATA_W   = ROW_BYTES * 8,
    localparam int MAX_SZ   = $clog2(ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_swap,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ROW_W-1:0]  mem_row,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    lane_state_e state_q, state_d;

    logic              store_q, swap_q;
    logic [ROW_W-1:0]  row_q;
    logic [OFF_W-1:0]  off_q;
    logic [SIZE_W-1:0] size_q;
    logic [DATA_W-1:0] wdata_q;

    // Legality of the incoming request
    logic       accept, legal;
    logic [3:0] width_m1;
    always_comb begin
        width_m1 = 4'((4'd1 << req_size) - 4'd1);
        legal    = (int'(req_size) <= MAX_SZ)
                && ((4'(req_addr[OFF_W-1:0]) & width_m1) == 4'd0);
        accept   = req_valid && (state_q == ST_IDLE);
    end

    // Datapath
    logic [DATA_W-1:0] st_swapped, merged, ld_extracted, ld_final;

    lane_swap #(.BYTES(ROW_BYTES)) i_st_swap (
        .din(wdata_q), .size(size_q), .en(swap_q), .dout(st_swapped));

    lane_merge #(.BYTES(ROW_BYTES)) i_merge (
        .row(mem_rdata), .wdata(st_swapped), .off(off_q), .size(size_q),
        .merged(merged));

    lane_extract #(.BYTES(ROW_BYTES)) i_extract (
        .row(mem_rdata), .off(off_q), .size(size_q), .dout(ld_extracted));

    lane_swap #(.BYTES(ROW_BYTES)) i_ld_swap (
        .din(ld_extracted), .size(size_q), .en(swap_q), .dout(ld_final));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = legal ? ST_FETCH : ST_FAULT;
            ST_FETCH: state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            store_q <= 1'b0;
            swap_q  <= 1'b0;
            row_q   <= '0;
            off_q   <= '0;
            size_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                store_q <= req_store;
                swap_q  <= req_swap;
                row_q   <= req_addr[ADDR_W-1:OFF_W];
                off_q   <= req_addr[OFF_W-1:0];
                size_q  <= req_size;
                wdata_q <= req_wdata;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_data  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_row   = row_q;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_re = 1'b1;
            ST_APPLY: begin
                rsp_valid = 1'b1;
                if (store_q) begin
                    mem_we    = 1'b1;
                    mem_wdata = merged;
                end else begin
                    rsp_data = ld_final;
                end
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lane_aligner_chk.sv
`timescale 1ns/1ps
module lane_aligner_chk #(
    parameter int ROW_BYTES = 8,
    parameter int ADDR_W    = 10,
    localparam int ROW_W    = ADDR_W - $clog2(ROW_BYTES),
    localparam int MAX_SZ   = $clog2(ROW_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              mem_re,
    input logic              mem_we,
    input logic [ROW_W-1:0]  mem_row
);
    logic [ADDR_W-1:0] low_mask;
    logic              bad_req, took;
    always_comb begin
        low_mask = ADDR_W'((1 << req_size) - 1);
        bad_req  = (int'(req_size) > MAX_SZ) || ((req_addr & low_mask) != '0);
        took     = req_valid && req_ready;
    end

    a_r2_fault_next: assert property (@(posedge clk) disable iff (!rst_n)
        (took && bad_req) |=> (rsp_valid && rsp_err && !mem_re && !mem_we));

    a_r2_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err);

    a_r3_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !bad_req) |=> mem_re);

    a_r3_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (rsp_valid && !rsp_err));

    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));

    a_r4_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $stable(mem_row));

    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we || rsp_valid) |-> !req_ready);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(mem_re || mem_we || rsp_valid || rsp_err));
endmodule

bind lane_aligner_top lane_aligner_chk #(
    .ROW_BYTES(ROW_BYTES),
    .ADDR_W(ADDR_W)
) i_chk (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr(req_addr),
    .req_size(req_size),
    .rsp_valid(rsp_valid),
    .rsp_err(rsp_err),
    .mem_re(mem_re),
    .mem_we(mem_we),
    .mem_row(mem_row)
);

// File: tb/test_lane_aligner_top.sv
`timescale 1ns/1ps
module test_lane_aligner_top;
    localparam int RB   = 8;
    localparam int AW   = 8;
    localparam int RW   = AW - 3;
    localparam int NROW = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_swap = 1'b0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [63:0]   rsp_data;
    logic          mem_re, mem_we;
    logic [RW-1:0] mem_row;
    logic [63:0]   mem_wdata;
    logic [63:0]   mem_rdata = '0;

    always #2.5 clk = ~clk;

    lane_aligner_top #(.ROW_BYTES(RB), .ADDR_W(AW)) i_lane_aligner_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_addr(req_addr), .req_size(req_size), .req_swap(req_swap),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .mem_re(mem_re), .mem_we(mem_we), .mem_row(mem_row),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    // Row memory model: one-cycle read latency, zero-initialised
    logic [63:0] mem_arr [NROW];
    initial for (int r = 0; r < NROW; r++) mem_arr[r] = '0;
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem_arr[mem_row];
        if (mem_we) mem_arr[mem_row] <= mem_wdata;
    end

    // Byte-level reference model
    logic [7:0] ref_mem [256];
    initial for (int b = 0; b < 256; b++) ref_mem[b] = 8'h00;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pattern(input int seed);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'((seed * 37 + k * 11 + 5) & 255);
        return v;
    endfunction

    function automatic logic [63:0] expect_load(input int a, input int n, input bit sw);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) v[k*8 +: 8] = ref_mem[a + (sw ? n - 1 - k : k)];
        return v;
    endfunction

    task automatic ref_store(input int a, input int n, input bit sw, input logic [63:0] wd);
        for (int k = 0; k < n; k++) ref_mem[a + (sw ? n - 1 - k : k)] = wd[k*8 +: 8];
    endtask

    // One request; returns response and observed timing at the ports
    task automatic access(input bit st, input int a, input int sz, input bit sw,
                          input logic [63:0] wd, output logic [63:0] d,
                          output logic e, output int lat, output int rd_n,
                          output int wr_n, output int row_seen, output bit busy_ok);
        @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready in idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_store = st; req_addr = AW'(a);
        req_size = 2'(sz); req_swap = sw; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0; rd_n = 0; wr_n = 0; row_seen = -1; busy_ok = 1'b1; d = '0; e = 1'b0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            lat++;
            if (req_ready) busy_ok = 1'b0;
            if (mem_re) begin rd_n++; row_seen = int'(mem_row); end
            if (mem_we) wr_n++;
            if (rsp_valid) begin d = rsp_data; e = rsp_err; break; end
        end
    endtask

    initial begin
        logic [63:0] d, wd, exp;
        logic        e;
        int lat, rd_n, wr_n, row_seen, seed;
        bit busy_ok;

        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready && !rsp_valid && !rsp_err && !mem_re && !mem_we,
            "R7 reset idle", {59'd0, req_ready, rsp_valid, rsp_err, mem_re, mem_we}, 64'h10);
        rst_n = 1'b1;

        // R3: load from a never-written row reads as zero
        access(1'b0, 8, 3, 1'b0, '0, d, e, lat, rd_n, wr_n, row_seen, busy_ok);
        chk(d == 64'd0 && !e, "R3 unwritten row", d, 64'd0);

        seed = 1;
        for (int sw = 0; sw < 2; sw++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int off = 0; off < 8; off++) begin
                    int n, row, a;
                    bit legal;
                    n     = 1 << sz;
                    row   = (sw * 16 + sz * 4 + off / 2) % NROW;
                    a     = row * 8 + off;
                    legal = (off % n) == 0;
                    wd    = pattern(seed);
                    seed++;

                    // Store
                    access(1'b1, a, sz, sw[0], wd, d, e, lat, rd_n, wr_n, row_seen, busy_ok);
                    if (legal) begin
                        ref_store(a, n, sw[0], wd);
                        chk(!e, "R2 legal store no error", 64'(e), 64'd0);
                        chk(lat == 2 && rd_n == 1 && wr_n == 1, "R4 store read-then-write timing",
                            64'(lat * 100 + rd_n * 10 + wr_n), 64'd211);
                        chk(row_seen == row, "R1 row index", 64'(row_seen), 64'(row));
                        chk(busy_ok, "R6 not ready while busy", 64'(busy_ok), 64'd1);
                    end else begin
                        chk(e && lat == 1, "R2 misaligned store error pulse",
                            64'(lat * 10 + int'(e)), 64'd11);
                        chk(rd_n == 0 && wr_n == 0, "R2 memory untouched",
                            64'(rd_n * 10 + wr_n), 64'd0);
                    end

                    // Load with same swap setting
                    access(1'b0, a, sz, sw[0], '0, d, e, lat, rd_n, wr_n, row_seen, busy_ok);
                    if (legal) begin
                        exp = expect_load(a, n, sw[0]);
                        chk(d == exp && !e, "R3 R5 load same swap", d, exp);
                        chk(lat == 2 && rd_n == 1 && wr_n == 0, "R3 load timing",
                            64'(lat * 100 + rd_n * 10 + wr_n), 64'd210);
                        // Load with opposite swap setting
                        access(1'b0, a, sz, !sw[0], '0, d, e, lat, rd_n, wr_n, row_seen, busy_ok);
                        exp = expect_load(a, n, !sw[0]);
                        chk(d == exp, "R5 load opposite swap", d, exp);
                    end else begin
                        chk(e && d == 64'd0 && rd_n == 0, "R2 misaligned load error",
                            d, 64'd0);
                    end

                    // Full-row read: neighbours preserved, junk upper bytes ignored
                    access(1'b0, row * 8, 3, 1'b0, '0, d, e, lat, rd_n, wr_n, row_seen, busy_ok);
                    exp = expect_load(row * 8, 8, 1'b0);
                    chk(d == exp, "R4 R8 full row after store", d, exp);
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R6 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule